// File: doc/BRIEF.md
# Interrupt-Capable GPIO Port

This block is one 32-pin general-purpose I/O port that sits behind a small memory-mapped register window. Software drives pins through an output-value register and an output-enable register. It reads the synchronised pin levels back through a read-only input register.

Each pin can also raise an interrupt. A select bit decides whether the pin takes part in detection at all. Two configuration bits choose between edge and level detection and between the two senses. Detected events latch into a sticky status register. The port's single interrupt line is active whenever a latched status bit is also enabled.

Every writable register has a plain-write address and three aliases: set, clear and toggle. Software can therefore change single bits without a read-modify-write sequence. The status register accepts only its clear alias.

Top module: `pin_port_irq`

## Requirements
- R1: After reset, every register reads 0, `pinOe` is 0 and `irqOut` is 0.
- R2: `busAddr[6:4]` selects the register: 0 output value, 1 input level, 2 output enable, 3 interrupt select, 4 interrupt enable, 5 level-select, 6 polarity, 7 status. `busAddr[3:2]` selects the access: 0 plain write, 1 set, 2 clear, 3 toggle. A read at any of the four aliases returns the register's value in the same cycle.
- R3: A set alias write ORs the data into the register. A clear alias write removes the bits written as 1. A toggle alias write inverts the bits written as 1. Bits written as 0 keep their value.
- R4: The input-level register shows each pin two clock edges after the pin changes. Writes to the input-level register have no effect.
- R5: `pinOut` equals the output-value register and `pinOe` equals the output-enable register.
- R6: The detection type is {polarity, level-select}: 00 falling edge, 01 low level, 10 rising edge, 11 high level. An edge sets its status bit on the third clock edge after the pin changes, and not earlier.
- R7: A pin whose interrupt-select bit is 0 never sets its status bit.
- R8: Status bits are sticky. Plain, set and toggle writes to the status register have no effect. Only ones written to the clear alias remove status bits.
- R9: A level-type pin sets its status bit on every cycle that its level is active. A clear issued while the level persists leaves the bit set. Once the level has gone, a clear removes the bit.
- R10: `irqOut` is the OR over all pins of (status AND enable). The enable register does not change status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Access valid this cycle |
| busWrite | input | 1 | 1 write, 0 read |
| busAddr | input | 7 | Byte address within the port window |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, combinational from address |
| pinIn | input | 32 | Raw pin levels |
| pinOut | output | 32 | Output value per pin |
| pinOe | output | 32 | Output enable per pin |
| irqOut | output | 1 | Combined port interrupt |

## Verification
A register write takes effect at the clock edge that captures it. A read returns that value combinationally, so readbacks are sampled 1 ns after the address settles. A pin change appears in the input-level register after two edges and in status after three. The bench changes pins just after a falling edge, counts rising edges from that point, and samples 1 ns after the due edge. It also samples one edge before the due edge to confirm the event is not early. `irqOut` follows status and enable without any register stage, so it is checked right after the write that alters either one.

// File: rtl/pin_port_pkg.sv
package pin_port_pkg;
  localparam int NUM_REGS = 8;
  localparam int REG_IDX_W = $clog2(NUM_REGS);
  localparam int ADDR_W = REG_IDX_W + 4;

  typedef enum logic [1:0] {
    ACC_WRITE = 2'd0,
    ACC_SET   = 2'd1,
    ACC_CLR   = 2'd2,
    ACC_TOG   = 2'd3
  } acc_e;

  typedef enum logic [REG_IDX_W-1:0] {
    RG_DOUT = 3'd0,
    RG_DIN  = 3'd1,
    RG_OE   = 3'd2,
    RG_SEL  = 3'd3,
    RG_EN   = 3'd4,
    RG_LEV  = 3'd5,
    RG_POL  = 3'd6,
    RG_STAT = 3'd7
  } reg_e;

  typedef struct packed {
    logic [NUM_REGS-1:0] wrHit;
    acc_e                acc;
    logic                rdEn;
    reg_e                rdSel;
  } strobe_t;
endpackage

// File: rtl/port_ctrl.sv
module port_ctrl
  import pin_port_pkg::*;
(
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  output strobe_t           strb
);
  logic [REG_IDX_W-1:0] regIdx;
  logic [1:0]           accField;

  assign regIdx   = busAddr[ADDR_W-1:4];
  assign accField = busAddr[3:2];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_hit
    assign strb.wrHit[i] = busSel && busWrite && (regIdx == REG_IDX_W'(i));
  end

  assign strb.acc   = acc_e'(accField);
  assign strb.rdEn  = busSel && !busWrite;
  assign strb.rdSel = reg_e'(regIdx);
endmodule

// File: rtl/alias_reg.sv
module alias_reg
  import pin_port_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         hit,
  input  acc_e         acc,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  logic [W-1:0] qNext;

  always_comb begin
    qNext = q;
    if (hit) begin
      unique case (acc)
        ACC_WRITE: qNext = wdata;
        ACC_SET:   qNext = q | wdata;
        ACC_CLR:   qNext = q & ~wdata;
        ACC_TOG:   qNext = q ^ wdata;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) q <= '0;
    else       q <= qNext;
  end
endmodule

// File: rtl/pin_event.sv
module pin_event #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] pinIn,
  input  logic [W-1:0] selBits,
  input  logic [W-1:0] levBits,
  input  logic [W-1:0] polBits,
  output logic [W-1:0] syncVal,
  output logic [W-1:0] evt
);
  logic [W-1:0] meta;
  logic [W-1:0] prevVal;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      meta    <= '0;
      syncVal <= '0;
      prevVal <= '0;
    end else begin
      meta    <= pinIn;
      syncVal <= meta;
      prevVal <= syncVal;
    end
  end

  for (genvar p = 0; p < W; p++) begin : g_pin
    logic hit;
    always_comb begin
      unique case ({polBits[p], levBits[p]})
        2'b00: hit = prevVal[p] & ~syncVal[p];
        2'b01: hit = ~syncVal[p];
        2'b10: hit = ~prevVal[p] & syncVal[p];
        2'b11: hit = syncVal[p];
      endcase
    end
    assign evt[p] = selBits[p] & hit;
  end
endmodule

// File: rtl/port_datapath.sv
module port_datapath
  import pin_port_pkg::*;
#(
  parameter int PIN_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strb,
  input  logic [PIN_W-1:0] wdata,
  input  logic [PIN_W-1:0] pinIn,
  output logic [PIN_W-1:0] rdata,
  output logic [PIN_W-1:0] pinOut,
  output logic [PIN_W-1:0] pinOe,
  output logic [PIN_W-1:0] statVec,
  output logic [PIN_W-1:0] selVec,
  output logic [PIN_W-1:0] enVec,
  output logic             irqOut
);
  logic [PIN_W-1:0] regQ [NUM_REGS];
  logic [PIN_W-1:0] syncVal;
  logic [PIN_W-1:0] evt;
  logic [PIN_W-1:0] statQ;
  logic [PIN_W-1:0] clrMask;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    if (i == int'(RG_DIN)) begin : g_din
      assign regQ[i] = syncVal;
    end else if (i == int'(RG_STAT)) begin : g_stat
      assign regQ[i] = statQ;
    end else begin : g_rw
      alias_reg #(.W(PIN_W)) u_reg (
        .clk   (clk),
        .rstN  (rstN),
        .hit   (strb.wrHit[i]),
        .acc   (strb.acc),
        .wdata (wdata),
        .q     (regQ[i])
      );
    end
  end

  pin_event #(.W(PIN_W)) u_event (
    .clk     (clk),
    .rstN    (rstN),
    .pinIn   (pinIn),
    .selBits (regQ[RG_SEL]),
    .levBits (regQ[RG_LEV]),
    .polBits (regQ[RG_POL]),
    .syncVal (syncVal),
    .evt     (evt)
  );

  assign clrMask = (strb.wrHit[RG_STAT] && strb.acc == ACC_CLR) ? wdata : '0;

  always_ff @(posedge clk) begin
    if (!rstN) statQ <= '0;
    else       statQ <= (statQ & ~clrMask) | evt;
  end

  assign rdata   = strb.rdEn ? regQ[strb.rdSel] : '0;
  assign pinOut  = regQ[RG_DOUT];
  assign pinOe   = regQ[RG_OE];
  assign statVec = statQ;
  assign selVec  = regQ[RG_SEL];
  assign enVec   = regQ[RG_EN];
  assign irqOut  = |(statQ & regQ[RG_EN]);
endmodule

// File: rtl/pin_port_irq.sv
module pin_port_irq
  import pin_port_pkg::*;
#(
  parameter int PIN_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [PIN_W-1:0]  busWdata,
  output logic [PIN_W-1:0]  busRdata,
  input  logic [PIN_W-1:0]  pinIn,
  output logic [PIN_W-1:0]  pinOut,
  output logic [PIN_W-1:0]  pinOe,
  output logic              irqOut
);
  strobe_t          strb;
  logic [PIN_W-1:0] statVec;
  logic [PIN_W-1:0] selVec;
  logic [PIN_W-1:0] enVec;

  port_ctrl u_ctrl (
    .busSel   (busSel),
    .busWrite (busWrite),
    .busAddr  (busAddr),
    .strb     (strb)
  );

  port_datapath #(.PIN_W(PIN_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .wdata   (busWdata),
    .pinIn   (pinIn),
    .rdata   (busRdata),
    .pinOut  (pinOut),
    .pinOe   (pinOe),
    .statVec (statVec),
    .selVec  (selVec),
    .enVec   (enVec),
    .irqOut  (irqOut)
  );
endmodule

// File: rtl/pin_port_irq_chk.sv
module pin_port_irq_chk #(
  parameter int PIN_W = 32,
  parameter int ADDR_W = 7
) (
  input logic              clk,
  input logic              rstN,
  input logic              busSel,
  input logic              busWrite,
  input logic [ADDR_W-1:0] busAddr,
  input logic [PIN_W-1:0]  pinOe,
  input logic [PIN_W-1:0]  statVec,
  input logic [PIN_W-1:0]  selVec,
  input logic [PIN_W-1:0]  enVec,
  input logic              irqOut
);
  logic statClrWr;
  logic anyWr;
  assign statClrWr = busSel && busWrite && (busAddr == ADDR_W'(8'h78));
  assign anyWr     = busSel && busWrite;

  AST_STAT_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    !$past(statClrWr) |-> ((statVec & $past(statVec)) == $past(statVec))); // R8

  AST_UNSEL_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    ((statVec & ~$past(statVec) & ~$past(selVec)) == '0)); // R7

  AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> (enVec != '0)); // R10

  AST_IRQ_NEEDS_STAT: assert property (@(posedge clk) disable iff (!rstN)
    (statVec == '0) |-> !irqOut); // R10

  AST_OE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !$past(anyWr) |-> $stable(pinOe)); // R5
endmodule

bind pin_port_irq pin_port_irq_chk #(.PIN_W(PIN_W), .ADDR_W(pin_port_pkg::ADDR_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .busSel   (busSel),
  .busWrite (busWrite),
  .busAddr  (busAddr),
  .pinOe    (pinOe),
  .statVec  (statVec),
  .selVec   (selVec),
  .enVec    (enVec),
  .irqOut   (irqOut)
);

// File: tb/pin_port_irq_test.sv
module pin_port_irq_test;
  logic        clk = 0;
  logic        rstN = 0;
  logic        busSel = 0;
  logic        busWrite = 0;
  logic [6:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [31:0] pinIn = '0;
  logic [31:0] pinOut;
  logic [31:0] pinOe;
  logic        irqOut;
  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  pin_port_irq uut (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .pinIn(pinIn), .pinOut(pinOut), .pinOe(pinOe), .irqOut(irqOut)
  );

  typedef struct packed {
    logic        wr;
    logic [6:0]  addr;
    logic [31:0] data;
    logic [31:0] exp;
  } vec_t;

  // R2/R3: aliases and access kinds; R4: a write to the input register is ignored
  localparam vec_t VECS [13] = '{
    '{1'b1, 7'h00, 32'hA5A5_0000, 32'h0},
    '{1'b0, 7'h00, 32'h0, 32'hA5A5_0000},
    '{1'b0, 7'h04, 32'h0, 32'hA5A5_0000},
    '{1'b1, 7'h04, 32'h0000_00FF, 32'h0},
    '{1'b0, 7'h00, 32'h0, 32'hA5A5_00FF},
    '{1'b1, 7'h08, 32'hA000_000F, 32'h0},
    '{1'b0, 7'h08, 32'h0, 32'h05A5_00F0},
    '{1'b1, 7'h0C, 32'hFFFF_0000, 32'h0},
    '{1'b0, 7'h0C, 32'h0, 32'hFA5A_00F0},
    '{1'b1, 7'h20, 32'h0000_FFFF, 32'h0},
    '{1'b0, 7'h24, 32'h0, 32'h0000_FFFF},
    '{1'b1, 7'h10, 32'hFFFF_FFFF, 32'h0},
    '{1'b0, 7'h1C, 32'h0, 32'h0}
  };

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk);
    busSel = 1; busWrite = 1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 0; busWrite = 0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [31:0] d);
    @(negedge clk);
    busSel = 1; busWrite = 0; busAddr = a;
    #1 d = busRdata;
    busSel = 0;
  endtask

  task automatic peek(input logic [6:0] a, output logic [31:0] d);
    busSel = 1; busWrite = 0; busAddr = a;
    #1 d = busRdata;
    busSel = 0;
  endtask

  task automatic pinSet(input logic [31:0] v);
    @(negedge clk);
    pinIn = v;
  endtask

  initial begin
    #(200000 * 10);
    total++; bad++;
    $display("FAIL watchdog got=%h exp=%h", 32'd0, 32'd1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1;

    // R1: reset state
    for (int r = 0; r < 8; r++) begin
      rd(7'(r * 16), v);
      check("R1 reg reset", v, 32'h0);
    end
    check("R1 pinOe", pinOe, 32'h0);
    check("R1 irqOut", {31'b0, irqOut}, 32'h0);

    for (int i = 0; i < 13; i++) begin
      if (VECS[i].wr) wr(VECS[i].addr, VECS[i].data);
      else begin
        rd(VECS[i].addr, v);
        check("R2 R3 R4 vector", v, VECS[i].exp);
      end
    end
    check("R5 pinOut", pinOut, 32'hFA5A_00F0);
    check("R5 pinOe", pinOe, 32'h0000_FFFF);
    wr(7'h00, 32'h0);
    wr(7'h20, 32'h0);

    // R6 rising edge on pin0, timing
    wr(7'h64, 32'h1);
    wr(7'h34, 32'h1);
    pinSet(32'h1);
    repeat (2) @(posedge clk);
    peek(7'h10, v); check("R4 din after two edges", v, 32'h1);
    peek(7'h70, v); check("R6 not early", v, 32'h0);
    @(posedge clk);
    peek(7'h70, v); check("R6 rise due", v, 32'h1);

    // R6 falling edge on pin1
    wr(7'h34, 32'h2);
    pinSet(32'h3);
    repeat (4) @(posedge clk);
    rd(7'h70, v); check("R6 rise ignored by fall type", v, 32'h1);
    pinSet(32'h1);
    repeat (3) @(posedge clk);
    rd(7'h70, v); check("R6 fall", v, 32'h3);

    // R7 unselected pin4
    wr(7'h64, 32'h10);
    pinSet(32'h11);
    repeat (4) @(posedge clk);
    rd(7'h70, v); check("R7 unselected", v, 32'h3);

    // R8 sticky status
    pinSet(32'h10);
    repeat (4) @(posedge clk);
    wr(7'h70, 32'h0);
    wr(7'h74, 32'hFFFF_FFFF);
    wr(7'h7C, 32'hFFFF_FFFF);
    rd(7'h70, v); check("R8 only clear alias", v, 32'h3);
    wr(7'h78, 32'h1);
    rd(7'h70, v); check("R8 clear", v, 32'h2);

    // R10 interrupt output
    check("R10 no enable", {31'b0, irqOut}, 32'h0);
    wr(7'h44, 32'h10);
    peek(7'h70, v); check("R10 enable without status", {31'b0, irqOut}, 32'h0);
    wr(7'h44, 32'h2);
    peek(7'h70, v); check("R10 asserted", {31'b0, irqOut}, 32'h1);
    wr(7'h48, 32'h12);
    peek(7'h70, v);
    check("R10 deasserted", {31'b0, irqOut}, 32'h0);
    check("R10 status kept", v, 32'h2);

    // R9 high level on pin2
    wr(7'h54, 32'h4);
    wr(7'h64, 32'h4);
    wr(7'h34, 32'h4);
    pinSet(32'h14);
    repeat (3) @(posedge clk);
    rd(7'h70, v); check("R9 high level", v, 32'h6);
    wr(7'h78, 32'h4);
    rd(7'h70, v); check("R9 reasserts", v, 32'h6);
    pinSet(32'h10);
    repeat (3) @(posedge clk);
    wr(7'h78, 32'h4);
    rd(7'h70, v); check("R9 clears after level", v, 32'h2);

    // R6 low level on pin3
    wr(7'h54, 32'h8);
    wr(7'h34, 32'h8);
    rd(7'h70, v); check("R6 low level", v, 32'hA);
    pinSet(32'h18);
    repeat (3) @(posedge clk);
    wr(7'h78, 32'h8);
    rd(7'h70, v); check("R9 low clears", v, 32'h2);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule